// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Elevation

This block chooses which interrupt request a processor core services next. It receives a vector of maskable requests, each already qualified by its own flag and local enable, and a small vector of nonmaskable requests. Each cycle it picks one winner and presents the winner's 8-bit vector identifier, which is the low byte of that source's vector address, together with a valid strobe. Maskable requests rank in a fixed order that follows the identifiers, from high to low. A programmable elevation register can move any single maskable source to the head of that order.

The block also holds the global maskable-interrupt mask (I) and the mask for the external nonmaskable request (X). When the core acknowledges a grant, the block saves I and X, sets I, and marks a service as in progress. No further grants are offered until a return pulse restores the saved masks. Stacking of core registers and the vector fetch belong to the core.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, I and X are both 1, no service is in progress, the elevation register holds 0x00, and no grant is offered for maskable requests.
- R2: Maskable source k has identifier 0xF2 - 2k, so source 0 is 0xF2 and source 1 is 0xF0. When no elevation matches, the pending source with the lowest index wins. A maskable grant is offered only while I is 0 and no service is in progress.
- R3: A write on the elevation port takes effect on the next cycle. If the stored value equals a source's identifier and that source is pending, that source wins over all other maskable requests.
- R4: An elevation value that matches no maskable identifier, such as 0x00, 0x55 or an odd value, leaves the fixed order unchanged.
- R5: Nonmaskable request j has identifier 0xF8 - 2j, and index 0 is the highest. Any eligible nonmaskable request wins over every maskable request, whether or not it is elevated, and it is offered whatever the value of I.
- R6: Nonmaskable index 2 is the external request. It is eligible only while X is 0. X is cleared by a pulse on x_clr, and no software input sets it again.
- R7: A pending software-trap request (index 1) is chosen ahead of the external request and all maskable requests, but index 0 overrides it.
- R8: An ack while a grant is offered sets I and marks a service in progress from the next cycle on. No grant is offered while a service is in progress, not even a nonmaskable one.
- R9: A ret during service ends the service on the next cycle and restores I to the value it had when the grant was acknowledged.
- R10: An ack while no grant is offered has no effect on the masks or on the service state.
- R11: Outside service, i_set sets I and i_clr clears it on the next cycle. When both are asserted together, i_set wins.
- R12: Acknowledging the external nonmaskable request also sets X during its service. A ret restores X to its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq | input | 8 | Qualified maskable requests, index 0 highest in the fixed order |
| nmi_req | input | 3 | Nonmaskable requests: 0 fatal trap, 1 software trap, 2 external |
| elev_we | input | 1 | Elevation register write strobe |
| elev_wdata | input | 8 | Identifier to elevate |
| i_set | input | 1 | Software set of I |
| i_clr | input | 1 | Software clear of I |
| x_clr | input | 1 | Software clear of X |
| ack | input | 1 | Core takes the offered grant |
| ret | input | 1 | Core returns from service |
| irq_valid | output | 1 | A grant is offered |
| irq_id | output | 8 | Identifier of the offered grant |
| i_mask | output | 1 | Current global maskable mask |
| x_mask | output | 1 | Current external nonmaskable mask |
| in_service | output | 1 | A service is in progress |

## Verification
The grant outputs are combinational, so irq_valid and irq_id are checked in the same cycle the request inputs change, after the inputs have settled and before the next edge. The elevation register, the masks and the service flag are registered. An elevation write, ack, ret or mask pulse applied in one cycle is checked in the following cycle, one edge later. The stimulus table therefore spends one cycle writing the elevation value and checks the grant in the next cycle.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    localparam int ID_W = 8;

    typedef logic [ID_W-1:0] vec_id_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_NMI  = 2'd1,
        SEL_MSK  = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e kind;
        vec_id_t   id;
        logic      is_ext;
    } grant_t;

    // identifiers step down by two from the top of each group
    function automatic vec_id_t idx_to_id(vec_id_t top, int idx);
        return vec_id_t'(int'(top) - 2 * idx);
    endfunction

endpackage

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/irqarb_elevate.sv
module irqarb_elevate
    import irqarb_pkg::*;
#(
    parameter int      N_SRC  = 8,
    parameter vec_id_t TOP_ID = 8'hF2,
    localparam int     IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  vec_id_t       wdata,
    output vec_id_t       elev_q,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    always_ff @(posedge clk) begin
        if (rst)     elev_q <= '0;
        else if (we) elev_q <= wdata;
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (elev_q == idx_to_id(TOP_ID, k)) begin
                hit     = 1'b1;
                hit_idx = IW'(k);
            end
        end
    end

    // R3: a write is visible in the following cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> elev_q == $past(wdata));
endmodule

// File: rtl/irqarb_mask_ctrl.sv
module irqarb_mask_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_ext,
    input  logic ret,
    input  logic i_set,
    input  logic i_clr,
    input  logic x_clr,
    output logic i_mask,
    output logic x_mask,
    output logic busy
);
    logic sv_i, sv_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            i_mask <= 1'b1;
            x_mask <= 1'b1;
            busy   <= 1'b0;
            sv_i   <= 1'b1;
            sv_x   <= 1'b1;
        end else if (take) begin
            busy   <= 1'b1;
            sv_i   <= i_mask;
            sv_x   <= x_mask;
            i_mask <= 1'b1;
            if (take_ext) x_mask <= 1'b1;
        end else if (busy && ret) begin
            busy   <= 1'b0;
            i_mask <= sv_i;
            x_mask <= sv_x;
        end else begin
            if (i_set)      i_mask <= 1'b1;
            else if (i_clr) i_mask <= 1'b0;
            if (x_clr)      x_mask <= 1'b0;
        end
    end

    // R8: taking a grant masks and enters service
    a_r8_take_masks: assert property (@(posedge clk) disable iff (rst)
        take |=> i_mask && busy);
    // R9: return leaves service and brings back the entry mask
    a_r9_ret_restores: assert property (@(posedge clk) disable iff (rst)
        busy && ret && !take |=> !busy && i_mask == $past(sv_i));
    // R12: taking the external request sets X
    a_r12_ext_sets_x: assert property (@(posedge clk) disable iff (rst)
        take && take_ext |=> x_mask);
    // R6: X only rises on a take or a return
    a_r6_x_rise_src: assert property (@(posedge clk) disable iff (rst)
        $rose(x_mask) |-> $past(take || (busy && ret)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irqarb_pkg::*;
#(
    parameter int      N_SRC  = 8,
    parameter int      N_NMI  = 3,
    parameter vec_id_t M_TOP  = 8'hF2,
    parameter vec_id_t NM_TOP = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] mreq,
    input  logic [N_NMI-1:0] nmi_req,
    input  logic             elev_we,
    input  logic [7:0]       elev_wdata,
    input  logic             i_set,
    input  logic             i_clr,
    input  logic             x_clr,
    input  logic             ack,
    input  logic             ret,
    output logic             irq_valid,
    output logic [7:0]       irq_id,
    output logic             i_mask,
    output logic             x_mask,
    output logic             in_service
);
    localparam int MIW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int NIW = (N_NMI > 1) ? $clog2(N_NMI) : 1;
    localparam int EXT = N_NMI - 1;

    logic [N_NMI-1:0] nmi_eff;
    logic             nmi_any, m_any, hit;
    logic [NIW-1:0]   nmi_idx;
    logic [MIW-1:0]   m_idx, hit_idx;
    vec_id_t          elev_q;
    grant_t           gnt;
    logic             take;

    always_comb begin
        nmi_eff      = nmi_req;
        nmi_eff[EXT] = nmi_req[EXT] & ~x_mask;
    end

    irqarb_pick #(.N(N_NMI), .IW(NIW)) u_nmi_pick (
        .req(nmi_eff), .any(nmi_any), .idx(nmi_idx));

    irqarb_pick #(.N(N_SRC), .IW(MIW)) u_msk_pick (
        .req(mreq), .any(m_any), .idx(m_idx));

    irqarb_elevate #(.N_SRC(N_SRC), .TOP_ID(M_TOP)) u_elev (
        .clk(clk), .rst(rst), .we(elev_we), .wdata(elev_wdata),
        .elev_q(elev_q), .hit(hit), .hit_idx(hit_idx));

    always_comb begin
        gnt = '{kind: SEL_NONE, id: '0, is_ext: 1'b0};
        if (nmi_any) begin
            gnt.kind   = SEL_NMI;
            gnt.id     = idx_to_id(NM_TOP, int'(nmi_idx));
            gnt.is_ext = (nmi_idx == NIW'(EXT));
        end else if (!i_mask && m_any) begin
            gnt.kind = SEL_MSK;
            gnt.id   = (hit && mreq[hit_idx]) ? elev_q
                                              : idx_to_id(M_TOP, int'(m_idx));
        end
    end

    assign irq_valid = !in_service && (gnt.kind != SEL_NONE);
    assign irq_id    = gnt.id;
    assign take      = ack && irq_valid;

    irqarb_mask_ctrl u_mask (
        .clk(clk), .rst(rst), .take(take), .take_ext(gnt.is_ext),
        .ret(ret), .i_set(i_set), .i_clr(i_clr), .x_clr(x_clr),
        .i_mask(i_mask), .x_mask(x_mask), .busy(in_service));

    // R8: nothing is offered during service
    a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
        in_service |-> !irq_valid);
    // R5: the top nonmaskable request wins whatever I holds
    a_r5_top_nmi: assert property (@(posedge clk) disable iff (rst)
        !in_service && nmi_req[0] |-> irq_valid && irq_id == NM_TOP);
    // R2: a maskable-only grant needs I clear
    a_r2_mask_gate: assert property (@(posedge clk) disable iff (rst)
        irq_valid && nmi_eff == '0 |-> !i_mask);
    // R3: a pending elevated source takes the maskable grant
    a_r3_elev_wins: assert property (@(posedge clk) disable iff (rst)
        !in_service && !i_mask && nmi_eff == '0 && hit && mreq[hit_idx]
        |-> irq_valid && irq_id == elev_q);
    // R6: external request alone is held off by X
    a_r6_x_gate: assert property (@(posedge clk) disable iff (rst)
        x_mask && nmi_req[EXT-1:0] == '0 && (i_mask || mreq == '0) |-> !irq_valid);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
    localparam time CYC = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mreq = '0;
    logic [2:0] nmi_req = '0;
    logic       elev_we = 1'b0;
    logic [7:0] elev_wdata = '0;
    logic       i_set = 1'b0, i_clr = 1'b0, x_clr = 1'b0, ack = 1'b0, ret = 1'b0;
    logic       irq_valid, i_mask, x_mask, in_service;
    logic [7:0] irq_id;

    int n_chk = 0;
    int n_bad = 0;

    always #(CYC/2) clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst(rst), .mreq(mreq), .nmi_req(nmi_req),
        .elev_we(elev_we), .elev_wdata(elev_wdata), .i_set(i_set),
        .i_clr(i_clr), .x_clr(x_clr), .ack(ack), .ret(ret),
        .irq_valid(irq_valid), .irq_id(irq_id), .i_mask(i_mask),
        .x_mask(x_mask), .in_service(in_service));

    // {elev, mreq, nmi, exp_valid, exp_id}; I=0, X=0, idle
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {8'h00, 8'b0000_0001, 3'b000, 1'b1, 8'hF2},  // R2
        {8'h00, 8'b1000_0000, 3'b000, 1'b1, 8'hE4},  // R2
        {8'h00, 8'b0110_0000, 3'b000, 1'b1, 8'hE8},  // R2
        {8'hF0, 8'b0000_0011, 3'b000, 1'b1, 8'hF0},  // R3
        {8'hE4, 8'b1000_0001, 3'b000, 1'b1, 8'hE4},  // R3
        {8'hE4, 8'b0000_0110, 3'b000, 1'b1, 8'hF0},  // R3 elevated idle
        {8'h55, 8'b1000_0001, 3'b000, 1'b1, 8'hF2},  // R4
        {8'hF1, 8'b1100_0000, 3'b000, 1'b1, 8'hE6},  // R4
        {8'h00, 8'b1111_1111, 3'b100, 1'b1, 8'hF4},  // R5 R6
        {8'h00, 8'b1111_1111, 3'b110, 1'b1, 8'hF6},  // R7
        {8'h00, 8'b0000_0000, 3'b111, 1'b1, 8'hF8},  // R7
        {8'h00, 8'b0000_0000, 3'b000, 1'b0, 8'h00},  // R2 idle
        {8'hE6, 8'b0100_0000, 3'b010, 1'b1, 8'hF6}   // R5
    };

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(CYC * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        mreq = 8'hFF;
        #5;
        chk("R1 i_mask", i_mask, 1);
        chk("R1 x_mask", x_mask, 1);
        chk("R1 in_service", in_service, 0);
        chk("R1 valid", irq_valid, 0);
        cyc();
        nmi_req = 3'b100; #5;
        chk("R6 ext held by X", irq_valid, 0);
        cyc();
        nmi_req = 3'b001; #5;
        chk("R5 valid with I set", irq_valid, 1);
        chk("R5 id", irq_id, 8'hF8);
        cyc();
        nmi_req = '0; mreq = '0; i_clr = 1'b1; x_clr = 1'b1;
        cyc();
        i_clr = 1'b0; x_clr = 1'b0; #5;
        chk("R11 i_clr", i_mask, 0);
        chk("R6 x_clr", x_mask, 0);

        for (int v = 0; v < NV; v++) begin
            cyc();
            elev_we = 1'b1; elev_wdata = VEC[v][27:20];
            cyc();
            elev_we = 1'b0; mreq = VEC[v][19:12]; nmi_req = VEC[v][11:9];
            #5;
            chk("R2/R3/R4/R5/R7 table valid", irq_valid, VEC[v][8]);
            if (VEC[v][8]) chk("R2/R3/R4/R5/R7 table id", irq_id, VEC[v][7:0]);
        end

        cyc();
        mreq = '0; nmi_req = '0; elev_we = 1'b1; elev_wdata = 8'h00;
        cyc();
        elev_we = 1'b0; mreq = 8'b0000_1000; ack = 1'b1; #5;
        chk("R2 src3 id", irq_id, 8'hEC);
        cyc();
        ack = 1'b0; nmi_req = 3'b001; #5;
        chk("R8 in_service", in_service, 1);
        chk("R8 i_mask", i_mask, 1);
        chk("R8 no grant in service", irq_valid, 0);
        cyc();
        ret = 1'b1;
        cyc();
        ret = 1'b0; nmi_req = '0; #5;
        chk("R9 service ends", in_service, 0);
        chk("R9 I restored clear", i_mask, 0);

        cyc();
        i_set = 1'b1; mreq = '0;
        cyc();
        i_set = 1'b0; nmi_req = 3'b001; ack = 1'b1;
        cyc();
        ack = 1'b0; nmi_req = '0; ret = 1'b1;
        cyc();
        ret = 1'b0; #5;
        chk("R9 I restored set", i_mask, 1);

        mreq = 8'h01; ack = 1'b1;
        cyc();
        ack = 1'b0; #5;
        chk("R10 ack ignored", in_service, 0);
        chk("R10 I unchanged", i_mask, 1);

        i_clr = 1'b1; mreq = '0;
        cyc();
        i_clr = 1'b0; nmi_req = 3'b100; ack = 1'b1; #5;
        chk("R12 ext id", irq_id, 8'hF4);
        cyc();
        ack = 1'b0; nmi_req = '0; #5;
        chk("R12 X set in service", x_mask, 1);
        chk("R12 I set in service", i_mask, 1);
        ret = 1'b1;
        cyc();
        ret = 1'b0; #5;
        chk("R12 X restored", x_mask, 0);

        i_set = 1'b1; i_clr = 1'b1;
        cyc();
        i_set = 1'b0; i_clr = 1'b0; #5;
        chk("R11 set wins", i_mask, 1);

        cyc();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule